// File: doc/BRIEF.md
# Maskable Interrupt Vector Generator

This block sits between a set of sixteen level-sensitive device request lines plus one hard-failure line and a processor core. It selects one pending source, raises a single request toward the core and drives a vector number beside it. The core answers with an acknowledge pulse. A device vector is the device line number added to an 8-bit base register. The base register is written through a small write port and comes out of reset at 32, so that device vectors stay above the processor's own exception numbers.

Device requests pass only while the core's interrupt-enable input is high. The hard-failure line does not depend on that enable. It is edge detected, wins over every device line, and always reports vector 2. Once a request is raised, it and its vector stay frozen until the acknowledge arrives. A device line that has been serviced is not reported again until it has gone low and then high again.

Top module: `irq_vec_gen`

## Requirements
- R1: After reset `irq_req_o` is 0 and the base register holds 32, so a lone request on line 0 reports vector 32.
- R2: With `ie_i` = 1 and one device line `k` high, `irq_req_o` rises one clock edge later and `vec_o` equals (base + k) modulo 256.
- R3: While `ie_i` = 0, no device line raises `irq_req_o`, whatever the device lines do.
- R4: When several eligible device lines are high, the lowest-numbered one is reported.
- R5: A rising edge on `nmi_i` raises `irq_req_o` with `vec_o` = 2 two clock edges later, whether `ie_i` is 0 or 1. Holding `nmi_i` high after it has been acknowledged raises nothing further.
- R6: When a hard-failure request and device requests are pending together, the hard-failure vector 2 is reported first.
- R7: Once `irq_req_o` is high, it and `vec_o` hold unchanged until `ack_i` is sampled high. At the edge where `ack_i` is sampled high, `irq_req_o` drops.
- R8: A device line that has been acknowledged is not reported again while it stays high. After it is seen low for at least one edge and then goes high again, it is reported again. Other pending lines are served in the meantime.
- R9: A write on `base_we_i` loads `base_wdata_i` into the base register. The new base applies to vectors captured afterwards, and the sum wraps modulo 256. A vector already presented is not changed by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_irq_i | input | 16 | Level-sensitive device request lines; bit k is line k |
| nmi_i | input | 1 | Hard-failure request, rising-edge detected |
| ie_i | input | 1 | Interrupt-enable flag from the core; gates device lines only |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 8 | Base register write data |
| ack_i | input | 1 | Acknowledge from the core for the presented request |
| irq_req_o | output | 1 | Request toward the core |
| vec_o | output | 8 | Vector of the presented request |

## Verification
Each of the sixteen lines is driven alone under four base values, including 0 and 250. This separates a correct add from an OR or a missing carry and confirms the wrap modulo 256. Priority is tried with every suffix pattern (lines k..15 high) and with pairs that always include line 15, which exposes encoders that pick the highest line or get stuck on a fixed line. The remaining sequences do four things. They hold a serviced line high next to a second line. They hold the hard-failure line high across its acknowledge. They raise it while a device request is already being presented. They change enable, lines and base during a pending request. These runs tell apart re-arming on level or on edge, priority applied at capture or at presentation, and a frozen vector or one that is still live.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEV  = 2'd1,
    SRC_NMI  = 2'd2
  } src_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (rise)       pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  AST_NMI_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_q) |=> pend_o); // R5
endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] served_i,
  output logic [NUM_LINES-1:0] elig_o
);
  logic [NUM_LINES-1:0] armed_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              armed_q[g] <= 1'b1;
      else if (!lines_i[g])     armed_q[g] <= 1'b1;
      else if (served_i[g])     armed_q[g] <= 1'b0;
    end
    assign elig_o[g] = lines_i[g] & armed_q[g];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned BASE_RST  = 32,
  parameter int unsigned NMI_VEC   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] dev_irq_i,
  input  logic                 nmi_i,
  input  logic                 ie_i,
  input  logic                 base_we_i,
  input  logic [VEC_W-1:0]     base_wdata_i,
  input  logic                 ack_i,
  output logic                 irq_req_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  src_e                 src_q;
  logic [IDX_W-1:0]     idx_q;
  vec_t                 vec_q;
  vec_t                 base_q;
  logic                 busy;
  logic                 ack_dev;
  logic                 ack_nmi;
  logic                 nmi_pend;
  logic [NUM_LINES-1:0] served;
  logic [NUM_LINES-1:0] elig;
  logic                 any_dev;
  logic [IDX_W-1:0]     sel_idx;

  assign busy    = (src_q != SRC_NONE);
  assign ack_dev = ack_i & (src_q == SRC_DEV);
  assign ack_nmi = ack_i & (src_q == SRC_NMI);

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      served[i] = ack_dev && (idx_q == IDX_W'(i));
    end
  end

  irq_nmi_edge u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (ack_nmi),
    .pend_o (nmi_pend)
  );

  irq_line_gate #(.NUM_LINES(NUM_LINES)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (dev_irq_i),
    .served_i (served),
    .elig_o   (elig)
  );

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
    .req_i (elig),
    .any_o (any_dev),
    .idx_o (sel_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= VEC_W'(BASE_RST);
    else if (base_we_i) base_q <= base_wdata_i;
  end

  // capture once, hold until acknowledged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_NONE;
      idx_q <= '0;
      vec_q <= '0;
    end else if (busy) begin
      if (ack_i) src_q <= SRC_NONE;
    end else if (nmi_pend) begin
      src_q <= SRC_NMI;
      vec_q <= VEC_W'(NMI_VEC);
    end else if (ie_i && any_dev) begin
      src_q <= SRC_DEV;
      idx_q <= sel_idx;
      vec_q <= base_q + VEC_W'(sel_idx);
    end
  end

  assign irq_req_o = busy;
  assign vec_o     = vec_q;

  AST_MASKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && !nmi_pend && !ie_i) |=> !irq_req_o); // R3
  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && nmi_pend) |=> (irq_req_o && vec_o == VEC_W'(NMI_VEC))); // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !ack_i) |=> (irq_req_o && $stable(vec_o))); // R7
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && ack_i) |=> !irq_req_o); // R7
endmodule

// File: tb/irq_vec_gen_tb.sv
module irq_vec_gen_tb;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] dev_irq_i;
  logic        nmi_i;
  logic        ie_i;
  logic        base_we_i;
  logic [7:0]  base_wdata_i;
  logic        ack_i;
  logic        irq_req_o;
  logic [7:0]  vec_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] base;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_vec_gen u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dev_irq_i    (dev_irq_i),
    .nmi_i        (nmi_i),
    .ie_i         (ie_i),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .ack_i        (ack_i),
    .irq_req_o    (irq_req_o),
    .vec_o        (vec_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic req_exp, input logic [7:0] vec_exp);
    n_chk++;
    if (irq_req_o !== req_exp || (req_exp && vec_o !== vec_exp)) begin
      n_fail++;
      $display("FAIL %s: actual req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irq_req_o, vec_o, req_exp, vec_exp);
    end
  endtask

  task automatic write_base(input logic [7:0] b);
    base_we_i = 1'b1; base_wdata_i = b;
    step();
    base_we_i = 1'b0;
    base = b;
  endtask

  task automatic ack_clear();
    ack_i = 1'b1; dev_irq_i = '0;
    step();
    ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R7: watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; dev_irq_i = '0; nmi_i = 1'b0; ie_i = 1'b0;
    base_we_i = 1'b0; base_wdata_i = '0; ack_i = 1'b0; base = 8'd32;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset idle", 1'b0, 8'd0);
    ie_i = 1'b1;
    dev_irq_i = 16'h0001;
    step();
    chk("R1 reset base", 1'b1, 8'd32);
    ack_clear();
    chk("R7 ack drops", 1'b0, 8'd0);

    // R2/R9: every line under several bases, including wrap
    for (int b = 0; b < 4; b++) begin
      case (b)
        0: write_base(8'd32);
        1: write_base(8'd0);
        2: write_base(8'd100);
        default: write_base(8'd250);
      endcase
      for (int i = 0; i < 16; i++) begin
        dev_irq_i = 16'(1) << i;
        step();
        chk("R2 R9 single line", 1'b1, 8'(base + i));
        ack_clear();
        chk("R7 ack drops", 1'b0, 8'd0);
      end
    end

    // R4: lowest line wins
    write_base(8'd40);
    for (int i = 0; i < 16; i++) begin
      dev_irq_i = ~((16'(1) << i) - 16'(1));
      step();
      chk("R4 suffix pattern", 1'b1, 8'(base + i));
      ack_clear();
      dev_irq_i = (16'(1) << i) | 16'h8000;
      step();
      chk("R4 pair with 15", 1'b1, 8'(base + i));
      ack_clear();
    end

    // R8: serviced line held high is not re-reported
    dev_irq_i = 16'h0008;
    step();
    chk("R8 first report", 1'b1, 8'(base + 3));
    ack_i = 1'b1; step(); ack_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 held high silent", 1'b0, 8'd0);
    end
    dev_irq_i = 16'h0000; step();
    chk("R8 deasserted", 1'b0, 8'd0);
    dev_irq_i = 16'h0008; step();
    chk("R8 re-reported", 1'b1, 8'(base + 3));
    ack_i = 1'b1; step(); ack_i = 1'b0;
    dev_irq_i = 16'h0208; step();
    chk("R8 other line served", 1'b1, 8'(base + 9));
    ack_clear();

    // R3: masked
    ie_i = 1'b0; dev_irq_i = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R3 masked", 1'b0, 8'd0);
    end
    ie_i = 1'b1; step();
    chk("R3 unmasked", 1'b1, 8'(base + 0));
    ack_clear();

    // R5: hard-failure line ignores enable, edge only
    ie_i = 1'b0; nmi_i = 1'b1;
    step();
    chk("R5 pend stage", 1'b0, 8'd0);
    step();
    chk("R5 nmi masked ie", 1'b1, 8'd2);
    ack_i = 1'b1; step(); ack_i = 1'b0;
    chk("R5 nmi ack", 1'b0, 8'd0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 level no retrigger", 1'b0, 8'd0);
    end
    nmi_i = 1'b0; step();
    nmi_i = 1'b1; step(); step();
    chk("R5 second edge", 1'b1, 8'd2);
    ack_i = 1'b1; nmi_i = 1'b0; step(); ack_i = 1'b0;

    // R6: hard-failure beats pending device line
    ie_i = 1'b1; dev_irq_i = 16'h0020;
    step();
    chk("R6 device presented", 1'b1, 8'(base + 5));
    nmi_i = 1'b1; dev_irq_i = 16'h00A0;
    step();
    chk("R7 held during nmi edge", 1'b1, 8'(base + 5));
    ack_i = 1'b1; step(); ack_i = 1'b0;
    chk("R7 ack drops", 1'b0, 8'd0);
    step();
    chk("R6 nmi first", 1'b1, 8'd2);
    nmi_i = 1'b0;
    ack_i = 1'b1; step(); ack_i = 1'b0;
    step();
    chk("R6 device after nmi", 1'b1, 8'(base + 7));
    ack_clear();

    // R7/R9: vector frozen across input changes, base write applies later
    dev_irq_i = 16'h0004;
    step();
    chk("R7 capture", 1'b1, 8'(base + 2));
    begin
      logic [7:0] held;
      held = 8'(base + 2);
      base_we_i = 1'b1; base_wdata_i = 8'd60; dev_irq_i = 16'h0001; ie_i = 1'b0;
      step();
      base_we_i = 1'b0; base = 8'd60;
      chk("R7 R9 frozen on write", 1'b1, held);
      for (int k = 0; k < 4; k++) begin
        dev_irq_i = 16'(16'h1111 << k);
        ie_i = k[0];
        step();
        chk("R7 frozen", 1'b1, held);
      end
    end
    ie_i = 1'b1;
    ack_clear();
    dev_irq_i = 16'h0002;
    step();
    chk("R9 new base used", 1'b1, 8'd61);
    ack_clear();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule